// File: doc/BRIEF.md
# Protected-register unlock sequencer

This block stands between a register bus and a group of guarded control registers. Software unlocks them by writing a fixed, ordered three-byte key to a single key address. The block follows each key write. When the full key has arrived in order, it raises a registered permission output, `prot_wr_ok`. Every block that owns guarded registers ANDs its own write strobe with this output. The same state can be read back as bit 0 of the key address.

Writes to other addresses and idle cycles do not affect the sequencer. A wrong byte written to the key address resets it to the start. If that wrong byte is the first key byte, the sequencer instead resumes at the second step. Once unlocked, the block stays unlocked only while further key writes follow the sequence or restart it. Any other key write locks it again.

Top module: `regprot_unlock`

## Requirements
- R1: While reset is asserted, and after reset is released, the block is locked: `prot_wr_ok` is 0 and a read of the key address (0x100) returns 0.
- R2: Three key-address writes in a row whose low bytes are 0x59, 0x16 and 0x88 unlock the block. From the clock edge that takes the third write, `prot_wr_ok` is 1 and bit 0 of a key-address read is 1. Bits above 7 of the written data play no part.
- R3: A key write whose low byte is neither the byte expected next nor 0x59 resets the sequence to its start. For example, 0x59, 0x16, 0x00, 0x88 leaves the block locked.
- R4: A key write of 0x59 in the middle of a sequence counts as the first byte of a new sequence. For example, 0x59, 0x16, 0x59, 0x16, 0x88 unlocks the block.
- R5: Writes to other addresses and cycles with no write leave the sequence position and the lock state unchanged.
- R6: While unlocked, a key write whose byte is neither the expected next byte nor 0x59 clears the lock state on that clock edge.
- R7: While unlocked, a key write of 0x59, or of the byte that correctly continues a sequence, keeps the block unlocked. Completing the sequence again leaves it unlocked.
- R8: Read data is combinational from the address. A key-address read returns the lock state in bit 0 and zero in every other bit. A read of any other address returns zero.
- R9: `prot_wr_ok` is a register that can change only on the clock edge that takes a key write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Bus write strobe, sampled on the rising clock edge |
| addr | input | ADDR_W (12) | Byte address for reads and writes |
| wdata | input | DATA_W (32) | Write data; the key byte is bits [7:0] |
| rdata | output | DATA_W (32) | Read data for `addr` |
| prot_wr_ok | output | 1 | Permission for guarded-register writes |

## Verification
Each write is taken on one rising edge. Its effect on `prot_wr_ok` and on the status bit is due on that same edge, with no further latency. `rdata` follows `addr` in the same cycle. The bench drives every write on a falling edge and holds it for exactly one rising edge. It samples both outputs at the following falling edge, which is the first point where the result of that write is defined. A bench model of the sequence rules is advanced once per write and supplies the expected values for the random runs.

// File: rtl/regprot_unlock.sv
module regprot_unlock #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] KEY_ADDR = 'h100,
  parameter logic [7:0] KEY0 = 8'h59,
  parameter logic [7:0] KEY1 = 8'h16,
  parameter logic [7:0] KEY2 = 8'h88
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              prot_wr_ok
);
  logic [1:0] stage, stage_nx;
  logic       unlocked, unlocked_nx;
  logic [7:0] code, want;
  logic       key_wr, hit, restart, done;
  logic       unused_hi;

  assign unused_hi = ^wdata[DATA_W-1:8];
  assign code      = wdata[7:0];
  assign key_wr    = wr_en && (addr == KEY_ADDR);
  assign want      = (stage == 2'd0) ? KEY0 : (stage == 2'd1) ? KEY1 : KEY2;
  assign hit       = (code == want);
  assign restart   = (code == KEY0);
  assign done      = hit && (stage == 2'd2);

  always_comb begin
    stage_nx    = stage;
    unlocked_nx = unlocked;
    if (key_wr) begin
      if (done)         stage_nx = 2'd0;
      else if (hit)     stage_nx = stage + 2'd1;
      else if (restart) stage_nx = 2'd1;
      else              stage_nx = 2'd0;
      unlocked_nx = done || (unlocked && (hit || restart));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage    <= 2'd0;
      unlocked <= 1'b0;
    end else begin
      stage    <= stage_nx;
      unlocked <= unlocked_nx;
    end
  end

  assign prot_wr_ok = unlocked;
  assign rdata = (addr == KEY_ADDR) ? {{(DATA_W-1){1'b0}}, unlocked} : '0;
endmodule

// File: rtl/regprot_unlock_chk.sv
module regprot_unlock_chk #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] KEY_ADDR = 'h100,
  parameter logic [7:0] KEY0 = 8'h59,
  parameter logic [7:0] KEY1 = 8'h16,
  parameter logic [7:0] KEY2 = 8'h88
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata,
  input logic              prot_wr_ok,
  input logic [1:0]        stage
);
  logic       kw;
  logic [7:0] b, nxt;
  assign kw  = wr_en && (addr == KEY_ADDR);
  assign b   = wdata[7:0];
  assign nxt = (stage == 2'd0) ? KEY0 : (stage == 2'd1) ? KEY1 : KEY2;

  always @(negedge clk)
    if (!rst_n) assert_locked_in_reset_R1: assert (!prot_wr_ok && rdata == '0);

  assert_unlock_on_last_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (kw && stage == 2'd2 && b == KEY2) |=> prot_wr_ok);

  assert_idle_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !kw |=> ($stable(prot_wr_ok) && $stable(stage)));

  assert_bad_key_locks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (kw && b != nxt && b != KEY0) |=> (!prot_wr_ok && stage == 2'd0));

  assert_restart_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (kw && prot_wr_ok && b == KEY0) |=> (prot_wr_ok && stage == 2'd1));

  assert_upper_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[DATA_W-1:1] == '0);

  assert_change_needs_key_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(prot_wr_ok) |-> $past(kw));
endmodule

bind regprot_unlock regprot_unlock_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY_ADDR(KEY_ADDR),
  .KEY0(KEY0), .KEY1(KEY1), .KEY2(KEY2)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .rdata(rdata), .prot_wr_ok(prot_wr_ok), .stage(stage)
);

// File: tb/regprot_unlock_tb.sv
module regprot_unlock_tb;
  localparam int AW = 12;
  localparam int DW = 32;
  localparam logic [AW-1:0] KA = 12'h100;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          prot_wr_ok;

  int checks = 0;
  int fails  = 0;
  int m_stage = 0;
  bit m_unl = 1'b0;

  regprot_unlock u_dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .prot_wr_ok(prot_wr_ok));

  always #10 clk = ~clk;

  function automatic logic [7:0] want_of(int s);
    return (s == 0) ? 8'h59 : (s == 1) ? 8'h16 : 8'h88;
  endfunction

  task automatic model_key(logic [7:0] v);
    bit h, r, d;
    h = (v == want_of(m_stage));
    r = (v == 8'h59);
    d = h && (m_stage == 2);
    m_unl = d || (m_unl && (h || r));
    if (d) m_stage = 0;
    else if (h) m_stage = m_stage + 1;
    else if (r) m_stage = 1;
    else m_stage = 0;
  endtask

  task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; addr = KA;
    if (a == KA) model_key(d[7:0]);
  endtask

  task automatic key(logic [7:0] v);
    wr(KA, {$urandom(), v} >> 0 & 32'hFFFF_FF00 | {24'h0, v});
  endtask

  task automatic expect_state(string tag);
    addr = KA;
    #1;
    chk(tag, {31'b0, prot_wr_ok}, {31'b0, m_unl});
    chk(tag, rdata, {31'b0, m_unl});
  endtask

  initial begin
    #4_000_000;
    fails++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R1 in reset", {31'b0, prot_wr_ok}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    expect_state("R1 after reset");

    key(8'h59); key(8'h16);
    expect_state("R2 partial key stays locked");
    key(8'h88);
    expect_state("R2 full key unlocks");
    addr = 12'h104; #1;
    chk("R8 other addr reads zero", rdata, 32'd0);
    key(8'h16);
    expect_state("R6 bad key relocks");

    key(8'h59); key(8'h16); key(8'h00); key(8'h88);
    expect_state("R3 broken sequence locked");

    key(8'h59); key(8'h16); key(8'h59); key(8'h16); key(8'h88);
    expect_state("R4 restart mid-sequence unlocks");

    key(8'h59);
    expect_state("R7 0x59 keeps unlocked");
    key(8'h16); key(8'h88);
    expect_state("R7 repeat sequence stays unlocked");

    key(8'h00);
    key(8'h59);
    wr(12'h018, 32'h0000_0016);
    repeat (3) @(negedge clk);
    key(8'h16); key(8'h88);
    expect_state("R5 other writes and idle ignored");

    for (int i = 0; i < 600; i++) begin
      int op;
      logic [7:0] v;
      op = $urandom_range(0, 9);
      case ($urandom_range(0, 3))
        0: v = 8'h59;
        1: v = 8'h16;
        2: v = 8'h88;
        default: v = 8'($urandom());
      endcase
      if (op < 7) key(v);
      else if (op < 9) wr(AW'($urandom_range(0, 255) * 4), $urandom());
      else @(negedge clk);
      expect_state("R9 random sequence");
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule